// File: doc/BRIEF.md
# Multi-channel DMA channel controller

This block holds the per-channel control registers for eight DMA channels and arbitrates the device side of each transfer. Software programs every channel through a word-addressed register port: an enable bit, a direction bit, a remaining byte count and a start address. A device then asks for a transfer by naming a channel, a length and a direction. The block checks the request against the channel's setup before it issues anything.

A request that passes the check is clamped to the remaining count and becomes one burst request on a simple memory-side request/done handshake. When the memory side reports completion, the count is reduced and a terminal-count flag is set. A request that fails the check moves no data. Instead it sets an error flag in the channel's status and a sticky per-channel bit in a non-maskable interrupt source register. Address translation and the data path are outside this block.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, all 32 channel registers, the interrupt source register, `nmi`, `dev_busy` and `mem_req` are zero.
- R2: Register `idx` of channel `ch` is read and written as a full word at byte offset 0x100 + ch*0x20 + idx*8, where idx 0 is mode, 1 is status/control, 2 is byte count and 3 is start address. In the status register, bit 0 enables the channel and bit 1 selects memory-to-device (0 means device-to-memory).
- R3: Offset 0x200 reads the interrupt source register, with bit n belonging to channel n, and ignores writes. Offset 0x208 always reads zero. Every other offset, including a channel offset with address bit 2 set, reads zero and ignores writes.
- R4: Each accepted device request first clears status bits 8 (terminal count), 9 (memory error) and 10 (address error) of its channel, whatever the outcome of the check.
- R5: A request to a disabled channel, or one whose `dev_m2d` differs from status bit 1, sets status bit 9 and interrupt source bit `ch`. It raises neither `mem_req` nor `dev_busy`.
- R6: A request that passes the check raises `mem_req` and `dev_busy` on the following cycle. At that point `mem_addr` equals the channel's address register, `mem_len` equals the smaller of `dev_len` and the count register, and `mem_m2d` equals status bit 1.
- R7: While `dev_busy` is high, `mem_req` and the memory-side fields hold their values until `mem_done`, and a device request has no effect on any register.
- R8: After `mem_done`, status bit 8 is set, the count register drops by `mem_len`, the address register is unchanged, and `dev_busy` and `mem_req` are low from the next cycle on.
- R9: Interrupt source bits stay set until reset, and `nmi` is high exactly when any source bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| dev_req | input | 1 | Device transfer request |
| dev_ch | input | 3 | Requested channel |
| dev_len | input | 32 | Requested length in bytes |
| dev_m2d | input | 1 | Requested direction, 1 = memory to device |
| dev_busy | output | 1 | A transfer is in flight; requests are ignored |
| mem_req | output | 1 | Burst request to memory side |
| mem_addr | output | 32 | Burst start address |
| mem_len | output | 32 | Burst length in bytes |
| mem_m2d | output | 1 | Burst direction, 1 = memory to device |
| mem_done | input | 1 | Memory side completion pulse |
| nmi | output | 1 | OR of all interrupt source bits |

## Verification
The embedded properties check the following on every cycle:
- the memory request and its fields stay stable until completion;
- a burst never exceeds the length the device asked for;
- a rejected request never starts a burst;
- completion always drops busy;
- interrupt source bits never clear;
- the interrupt output only rises right after a device request.

The bench scenarios are needed for the rest:
- the exact register values and the address decode;
- the clamping against the count;
- the count arithmetic;
- the flag clearing on each request;
- proof that requests arriving during a busy transfer leave every register untouched.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_wr,
  input  logic [AW-1:0] csr_addr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  input  logic          dev_req,
  input  logic [CW-1:0] dev_ch,
  input  logic [DW-1:0] dev_len,
  input  logic          dev_m2d,
  output logic          dev_busy,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_len,
  output logic          mem_m2d,
  input  logic          mem_done,
  output logic          nmi
);
  localparam int IX_STAT = 1;
  localparam int IX_CNT  = 2;
  localparam int IX_ADR  = 3;
  localparam logic [DW-1:0] FL_TC   = DW'(32'h100);
  localparam logic [DW-1:0] FL_MERR = DW'(32'h200);
  localparam logic [DW-1:0] FL_ALL  = DW'(32'h700);

  logic [DW-1:0] chr [NCH][4];
  logic [NCH-1:0] nmi_src;
  logic           busy;
  logic [CW-1:0]  act_ch;
  logic [DW-1:0]  act_len, act_adr;
  logic           act_m2d;

  wire [2:0]  csr_ch  = csr_addr[7:5];
  wire [1:0]  csr_idx = csr_addr[4:3];
  wire chan_hit = (csr_addr[AW-1:9] == '0) && csr_addr[8] && !csr_addr[2]
                  && (32'(csr_ch) < NCH);
  wire nmi_hit  = csr_addr[AW-1:2] == (AW-2)'(10'h080);

  wire [DW-1:0] dstat  = chr[dev_ch][IX_STAT];
  wire [DW-1:0] dcnt   = chr[dev_ch][IX_CNT];
  wire          dev_ok = dstat[0] && (dstat[1] == dev_m2d);
  wire [DW-1:0] clamp  = (dev_len < dcnt) ? dev_len : dcnt;
  wire          take   = dev_req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int i = 0; i < 4; i++) chr[c][i] <= '0;
      nmi_src <= '0;
      busy    <= 1'b0;
      act_ch  <= '0;
      act_len <= '0;
      act_adr <= '0;
      act_m2d <= 1'b0;
    end else begin
      if (csr_wr && chan_hit) chr[csr_ch[CW-1:0]][csr_idx] <= csr_wdata;
      if (take) begin
        if (dev_ok) begin
          chr[dev_ch][IX_STAT] <= dstat & ~FL_ALL;
          busy    <= 1'b1;
          act_ch  <= dev_ch;
          act_len <= clamp;
          act_adr <= chr[dev_ch][IX_ADR];
          act_m2d <= dstat[1];
        end else begin
          chr[dev_ch][IX_STAT] <= (dstat & ~FL_ALL) | FL_MERR;
          nmi_src[dev_ch] <= 1'b1;
        end
      end
      if (busy && mem_done) begin
        chr[act_ch][IX_STAT] <= chr[act_ch][IX_STAT] | FL_TC;
        chr[act_ch][IX_CNT]  <= chr[act_ch][IX_CNT] - act_len;
        busy <= 1'b0;
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (chan_hit)     csr_rdata = chr[csr_ch[CW-1:0]][csr_idx];
    else if (nmi_hit) csr_rdata = DW'(nmi_src);
  end

  assign dev_busy = busy;
  assign mem_req  = busy;
  assign mem_addr = act_adr;
  assign mem_len  = act_len;
  assign mem_m2d  = act_m2d;
  assign nmi      = |nmi_src;

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_m2d));
  // R6
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_len <= $past(dev_len));
  // R5
  reject_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !dev_ok |=> !mem_req);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_done |=> !dev_busy);
  // R9
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((nmi_src & $past(nmi_src)) == $past(nmi_src)));
  // R9
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(dev_req && !dev_busy));
endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb_top;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic csr_wr = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic dev_req = 0, dev_m2d = 0;
  logic [2:0] dev_ch = 0;
  logic [31:0] dev_len = 0;
  logic dev_busy, mem_req, mem_m2d, nmi;
  logic [31:0] mem_addr, mem_len;
  logic mem_done = 0;
  int errors = 0, checks = 0;
  logic [31:0] m [8][4];
  logic [7:0] mnmi;

  always #(PERIOD/2) clk = ~clk;

  dma_chan_ctrl dut_i (.clk, .rst_n, .csr_wr, .csr_addr, .csr_wdata, .csr_rdata,
    .dev_req, .dev_ch, .dev_len, .dev_m2d, .dev_busy, .mem_req, .mem_addr,
    .mem_len, .mem_m2d, .mem_done, .nmi);

  function automatic logic [11:0] roff(int c, int i);
    return 12'(32'h100 + c*32'h20 + i*8);
  endfunction

  function automatic logic [31:0] mn(logic [31:0] a, logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(string r, logic [11:0] a, logic [31:0] exp);
    csr_addr = a; #1; chk(r, csr_rdata, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_wr = 1; csr_addr = a; csr_wdata = d;
    if (a[11:8] == 4'h1 && !a[2]) m[a[7:5]][a[4:3]] = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic all_regs(string r);
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 4; i++) rd(r, roff(c, i), m[c][i]);
    rd("R9", 12'h200, {24'h0, mnmi});
    chk("R9", 32'(nmi), 32'(|mnmi));
  endtask

  task automatic dreq(int c, logic [31:0] len, logic d, int wait_cyc);
    logic ok;
    logic [31:0] el;
    int oc;
    ok = m[c][1][0] && (m[c][1][1] == d);
    el = mn(len, m[c][2]);
    m[c][1] = m[c][1] & ~32'h700;
    @(negedge clk);
    dev_req = 1; dev_ch = 3'(c); dev_len = len; dev_m2d = d;
    @(negedge clk);
    dev_req = 0;
    if (!ok) begin
      m[c][1] = m[c][1] | 32'h200; mnmi[c] = 1'b1;
      chk("R5", {30'h0, mem_req, dev_busy}, 32'h0);
    end else begin
      chk("R6", {30'h0, mem_req, dev_busy}, 32'h3);
      chk("R6", mem_addr, m[c][3]);
      chk("R6", mem_len, el);
      chk("R6", 32'(mem_m2d), 32'(m[c][1][1]));
      oc = (c + 1) % 8;
      for (int w = 0; w < wait_cyc; w++) begin
        dev_req = 1; dev_ch = 3'(oc); dev_len = 32'h10; dev_m2d = ~m[oc][1][1];
        @(negedge clk);
        chk("R7", {30'h0, mem_req, dev_busy}, 32'h3);
        chk("R7", mem_len, el);
      end
      dev_req = 0;
      mem_done = 1;
      @(negedge clk);
      mem_done = 0;
      chk("R8", {30'h0, mem_req, dev_busy}, 32'h0);
      m[c][1] = m[c][1] | 32'h100;
      m[c][2] = m[c][2] - el;
    end
    all_regs(ok ? "R8" : "R4");
  endtask

  initial begin
    #(PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 8; c++) for (int i = 0; i < 4; i++) m[c][i] = 0;
    mnmi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    all_regs("R1");
    chk("R1", {29'h0, nmi, dev_busy, mem_req}, 32'h0);
    // R2 full map write/readback
    for (int c = 0; c < 8; c++) for (int i = 0; i < 4; i++) wr(roff(c, i), $urandom);
    all_regs("R2");
    // R3 unmapped, read-only, error type
    wr(12'h200, 32'hffff_ffff);
    wr(12'h104, 32'h1234_5678);
    rd("R3", 12'h104, 32'h0);
    rd("R3", 12'h208, 32'h0);
    rd("R3", 12'h040, 32'h0);
    rd("R3", 12'h200, 32'h0);
    all_regs("R3");
    // R4/R5 disabled channel with stale flags
    wr(roff(2, 1), 32'h0000_0700);
    dreq(2, 32'h40, 1'b0, 0);
    rd("R4", roff(2, 1), 32'h200);
    rd("R5", 12'h200, 32'h4);
    // R5 direction mismatch
    wr(roff(5, 1), 32'h0000_0403);
    dreq(5, 32'h40, 1'b0, 0);
    rd("R5", roff(5, 1), 32'h203);
    // R6/R8 clamp: requested above count
    wr(roff(1, 1), 32'h0000_0501);
    wr(roff(1, 2), 32'h0000_0030);
    wr(roff(1, 3), 32'h8000_1000);
    dreq(1, 32'h100, 1'b0, 2);
    rd("R8", roff(1, 2), 32'h0);
    rd("R8", roff(1, 1), 32'h101);
    rd("R8", roff(1, 3), 32'h8000_1000);
    // R6 zero count -> zero length burst
    dreq(1, 32'h20, 1'b0, 0);
    // R6 below count, mem-to-dev
    wr(roff(6, 1), 32'h3);
    wr(roff(6, 2), 32'h1000);
    dreq(6, 32'h80, 1'b1, 3);
    rd("R8", roff(6, 2), 32'hf80);
    // random mix
    for (int n = 0; n < 300; n++) begin
      int c;
      c = $urandom_range(0, 7);
      case ($urandom_range(0, 3))
        0: wr(roff(c, 1), ($urandom & 32'h0000_0703) | (($urandom_range(0,3) != 0) ? 32'h1 : 32'h0));
        1: wr(roff(c, 2), $urandom_range(0, 512));
        2: wr(roff(c, $urandom_range(0, 3)), $urandom);
        default: dreq(c, $urandom_range(0, 600), 1'($urandom_range(0, 1)), $urandom_range(0, 3));
      endcase
    end
    all_regs("R9");
    // R1 reset clears sticky state
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < 8; c++) for (int i = 0; i < 4; i++) m[c][i] = 0;
    mnmi = 0;
    @(negedge clk);
    all_regs("R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule